// File: doc/BRIEF.md
# Smart-card half-duplex UART transceiver

This block is an asynchronous serial transceiver for a single shared open-drain wire of the kind used on smart-card links. Transmitter and receiver both see the same line. Each frame has a low start bit, eight data bits sent least significant bit first, an even parity bit and one high stop bit. Logic levels are not inverted. A free-running divider makes a sub-bit tick every `divisor + 1` clocks, and one bit lasts sixteen ticks.

A receiver that finds a parity mismatch pulls the line low for one whole bit time, starting where the stop bit begins. The sending side looks at the line in the middle of its own stop bit. If it reads low there, it latches a sticky remote-error flag that the host can clear. The host side is a simple strobe interface:
- Writing the transmit buffer moves the byte into the shifter as soon as the shifter is free.
- Level flags report buffer-empty, transmit-complete, receive-full and local parity error.
- Two interrupt request flags stay set until the host acknowledges them.

Top module: `sc_uart`

## Requirements
- R1: A transmitted frame is eleven bit slots on the line: slot 0 is low (start), slots 1 to 8 carry data bits 0 to 7, slot 9 is the even parity bit (XOR of the eight data bits), and slot 10 is high (stop).
- R2: Every bit slot after the start bit lasts exactly 16 × (divisor + 1) clock cycles.
- R3: A `wr_stb` while `tx_en` is 1 puts the byte in the buffer. If the shifter is idle, the byte moves into it on the next clock and `txbuf_empty` returns to 1. A `wr_stb` while `tx_en` is 0 is ignored: no frame starts and the flags do not change.
- R4: `tx_done` is 1 when the shifter is idle and the buffer is empty. It goes to 0 on the clock after an accepted write and stays 0 until the stop slot has ended.
- R5: `tx_irq` is set at the end of each transmitted stop slot, not when the buffer empties. It stays set until a cycle with `irq_ack_tx` high.
- R6: The transmitter samples the line at the middle of its stop slot. A low level sets the sticky flag `perr_seen`, which only `perr_clr` clears.
- R7: The receiver starts a frame on a high-to-low line transition while `rx_en` is 1 and the transmitter is idle. If the line is high again at the middle of the start bit, it drops the frame and reports nothing.
- R8: At the end of a received frame's stop slot, the data byte appears on `rd_data` and `rx_full` and `rx_irq` are set. `rx_full` clears on `rd_stb`. `rx_irq` stays set until `irq_ack_rx`.
- R9: If the received parity bit does not make the total count of ones even, the receiver pulls `line_drive_low` high for the whole stop slot and `rx_perr` reads 1 for that frame. A correct frame leaves the line released and `rx_perr` at 0.
- R10: A second write while a frame is being sent is held in the buffer (`txbuf_empty` at 0). It is sent right after the current frame ends.
- R11: After reset the line is released, `txbuf_empty`, `tx_done` are 1, and `rx_full`, `tx_irq`, `rx_irq`, `perr_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count clock of the divider |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | DIV_W | Divider value n; tick every n+1 clocks |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wr_stb | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_stb | input | 1 | Read strobe; clears rx_full |
| rd_data | output | DATA_W | Last received byte |
| irq_ack_tx | input | 1 | Clears tx_irq |
| irq_ack_rx | input | 1 | Clears rx_irq |
| perr_clr | input | 1 | Clears perr_seen |
| line_i | input | 1 | Level of the shared wire |
| line_drive_low | output | 1 | 1 pulls the shared wire low (open drain) |
| txbuf_empty | output | 1 | Transmit buffer can take a byte |
| tx_done | output | 1 | Shifter idle and buffer empty |
| rx_full | output | 1 | Unread received byte present |
| rx_perr | output | 1 | Last received frame had a parity mismatch |
| perr_seen | output | 1 | Far end reported a parity error (sticky) |
| tx_irq | output | 1 | Transmit-complete interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The transmit path is tried with several bytes of different parity at divisor 0, and at divisor 2 where the measured bit time separates a correct divider from one that is off by a count. Frames that are answered by an injected low pulse in the stop slot are compared with clean frames, which separates a stop-slot sampler from one that ignores the line or reads the wrong slot. On the receive side the bench sends a good-parity frame, a bad-parity frame and a three-cycle glitch. These tell apart a correct error pulse from a missing one or one that is always present, and a working mid-start check from a receiver that accepts any falling edge. Two back-to-back writes and a write with transmit disabled show whether the buffer hand-off and the enable gating work.

// File: rtl/sc_uart_pkg.sv
// Shared constants and types for the smart-card UART.
// Assumes a fixed oversampling of sixteen sub-bit ticks per bit.
package sc_uart_pkg;
    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);
    localparam int MID   = OVS / 2 - 1;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/sc_tick_gen.sv
// Free-running sub-bit tick generator: pulses tick once every divisor+1 clocks.
// Assumes divisor may change at any time; a lowered value takes effect at once.
module sc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divisor);

    // Count up to the divisor value, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sc_tx.sv
// Transmit side: one-byte buffer, frame shifter and stop-slot error sampler.
// Assumes line_i is the level of the shared wire, already in the clk domain.
module sc_tx
    import sc_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_i,
    input  logic              perr_clr,
    output logic              drive_low,
    output logic              busy,
    output logic              buf_empty,
    output logic              frame_done,
    output logic              perr_seen
);
    localparam int FRAME = DATA_W + 3;
    localparam int IDX_W = $clog2(FRAME);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME - 1);
    localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] SUB_MID  = OVS_W'(MID);

    logic [DATA_W-1:0] buf_q;
    logic              buf_full;
    logic [FRAME-1:0]  frame_q;
    logic              busy_q;
    logic [IDX_W-1:0]  idx;
    logic [OVS_W-1:0]  sub;
    logic              perr_q;
    logic              accept;
    logic              load;

    assign accept     = wr_stb & tx_en;
    assign load       = buf_full & ~busy_q & tx_en;
    assign frame_done = busy_q & tick & (sub == SUB_LAST) & (idx == IDX_LAST);
    assign drive_low  = busy_q & ~frame_q[idx];
    assign busy       = busy_q;
    assign buf_empty  = ~buf_full;
    assign perr_seen  = perr_q;

    // Hold one byte; a new write wins over the hand-off in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
        end else begin
            if (load)   buf_full <= 1'b0;
            if (accept) begin
                buf_q    <= wr_data;
                buf_full <= 1'b1;
            end
        end
    end

    // Load a full frame and step through its slots, sixteen ticks each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
            busy_q  <= 1'b0;
            idx     <= '0;
            sub     <= '0;
        end else if (load) begin
            frame_q <= {1'b1, ^buf_q, buf_q, 1'b0};
            busy_q  <= 1'b1;
            idx     <= '0;
            sub     <= '0;
        end else if (busy_q && tick) begin
            if (sub == SUB_LAST) begin
                sub <= '0;
                if (idx == IDX_LAST) busy_q <= 1'b0;
                else                 idx    <= idx + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // Sample the wire mid stop slot; a low level records a remote parity error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perr_q <= 1'b0;
        else if (busy_q && tick && idx == IDX_LAST && sub == SUB_MID && !line_i)
            perr_q <= 1'b1;
        else if (perr_clr)
            perr_q <= 1'b0;
    end
endmodule

// File: rtl/sc_rx.sv
// Receive side: start detection with mid-start glitch rejection, bit sampling
// at the middle tick, parity check and a one-bit error pulse in the stop slot.
// Assumes line_i is synchronous to clk; hold keeps it from starting on own frames.
module sc_rx
    import sc_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              hold,
    input  logic              line_i,
    output logic              err_drive,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr
);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_PAR  = IDX_W'(DATA_W);
    localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] SUB_MID  = OVS_W'(MID);

    rx_state_e        state;
    logic [OVS_W-1:0] sub;
    logic [IDX_W-1:0] idx;
    logic [DATA_W:0]  shreg;
    logic             line_q;
    logic             err_q;

    assign err_drive = (state == RX_STOP) & err_q;
    assign done      = (state == RX_STOP) & tick & (sub == SUB_LAST);
    assign data      = shreg[DATA_W-1:0];
    assign perr      = err_q;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_i;
    end

    // Frame sequencer: start, nine sampled bits, stop slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            idx   <= '0;
            shreg <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (rx_en && !hold && line_q && !line_i) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (sub == SUB_MID && line_i) begin
                            state <= RX_IDLE;
                        end else if (sub == SUB_LAST) begin
                            state <= RX_BITS;
                            sub   <= '0;
                            idx   <= '0;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (sub == SUB_MID) shreg <= {line_i, shreg[DATA_W:1]};
                        if (sub == SUB_LAST) begin
                            sub <= '0;
                            if (idx == IDX_PAR) begin
                                state <= RX_STOP;
                                err_q <= ^shreg;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (sub == SUB_LAST) begin
                            state <= RX_IDLE;
                            sub   <= '0;
                            err_q <= 1'b0;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_uart.sv
// Smart-card half-duplex UART top: ties the tick generator, transmitter and
// receiver to one open-drain wire and keeps the host-visible flags.
// Assumes the board resolves the wire as the AND of all open-drain drivers.
module sc_uart #(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_ack_tx,
    input  logic              irq_ack_rx,
    input  logic              perr_clr,
    input  logic              line_i,
    output logic              line_drive_low,
    output logic              txbuf_empty,
    output logic              tx_done,
    output logic              rx_full,
    output logic              rx_perr,
    output logic              perr_seen,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic              tick;
    logic              tx_low;
    logic              tx_busy;
    logic              tx_fin;
    logic              rx_low;
    logic              rx_fin;
    logic [DATA_W-1:0] rx_data;
    logic              rx_bad;
    logic [DATA_W-1:0] rd_q;
    logic              full_q;
    logic              perr_q;
    logic              tirq_q;
    logic              rirq_q;

    sc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    sc_tx #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_en      (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .line_i     (line_i),
        .perr_clr   (perr_clr),
        .drive_low  (tx_low),
        .busy       (tx_busy),
        .buf_empty  (txbuf_empty),
        .frame_done (tx_fin),
        .perr_seen  (perr_seen)
    );

    sc_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_en     (rx_en),
        .hold      (tx_busy),
        .line_i    (line_i),
        .err_drive (rx_low),
        .done      (rx_fin),
        .data      (rx_data),
        .perr      (rx_bad)
    );

    assign line_drive_low = tx_low | rx_low;
    assign tx_done        = ~tx_busy & txbuf_empty;
    assign rd_data        = rd_q;
    assign rx_full        = full_q;
    assign rx_perr        = perr_q;
    assign tx_irq         = tirq_q;
    assign rx_irq         = rirq_q;

    // Capture a finished frame; a completing frame wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            full_q <= 1'b0;
            perr_q <= 1'b0;
        end else if (rx_fin) begin
            rd_q   <= rx_data;
            full_q <= 1'b1;
            perr_q <= rx_bad;
        end else if (rd_stb) begin
            full_q <= 1'b0;
        end
    end

    // Interrupt request flags: set on an event, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tirq_q <= 1'b0;
            rirq_q <= 1'b0;
        end else begin
            if (tx_fin)          tirq_q <= 1'b1;
            else if (irq_ack_tx) tirq_q <= 1'b0;
            if (rx_fin)          rirq_q <= 1'b1;
            else if (irq_ack_rx) rirq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_uart_chk.sv
// Protocol checker for sc_uart, attached through bind below.
// Assumes only the top-level ports; it looks at no internal signal.
module sc_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic rd_stb,
    input logic irq_ack_tx,
    input logic irq_ack_rx,
    input logic perr_clr,
    input logic txbuf_empty,
    input logic tx_done,
    input logic rx_full,
    input logic tx_irq,
    input logic rx_irq,
    input logic perr_seen
);
    // R3
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !tx_en && txbuf_empty) |=> txbuf_empty);

    // R4
    done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_en && tx_done) |=> !tx_done);

    // R5
    tx_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !irq_ack_tx) |=> tx_irq);

    // R6
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_seen && !perr_clr) |=> perr_seen);

    // R8
    rx_full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_stb));

    // R8
    rx_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !irq_ack_rx) |=> rx_irq);
endmodule

bind sc_uart sc_uart_chk u_chk (.*);

// File: tb/sc_uart_test.sv
// Directed bench for sc_uart: one task per scenario, each checking its results.
module sc_uart_test;
    localparam int DIV_W  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  divisor = '0;
    logic              tx_en = 1'b0, rx_en = 1'b0;
    logic              wr_stb = 1'b0, rd_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq_ack_tx = 1'b0, irq_ack_rx = 1'b0, perr_clr = 1'b0;
    logic              line_drive_low, txbuf_empty, tx_done, rx_full, rx_perr;
    logic              perr_seen, tx_irq, rx_irq;
    logic              far_low = 1'b0;
    logic              line;
    int                n_chk = 0, n_bad = 0;
    bit                finished = 1'b0;

    assign line = ~(line_drive_low | far_low);

    always #10 clk = ~clk;

    sc_uart #(.DIV_W(DIV_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tx_en(tx_en), .rx_en(rx_en),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .irq_ack_tx(irq_ack_tx), .irq_ack_rx(irq_ack_rx), .perr_clr(perr_clr),
        .line_i(line), .line_drive_low(line_drive_low), .txbuf_empty(txbuf_empty),
        .tx_done(tx_done), .rx_full(rx_full), .rx_perr(rx_perr),
        .perr_seen(perr_seen), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] frame_of(input logic [7:0] d, input bit badp);
        return {1'b1, (^d) ^ badp, d, 1'b0};
    endfunction

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Wait for a frame on the wire and sample each slot mid-way; optionally
    // answer with a one-bit low pulse in the stop slot.
    task automatic grab(input int bc, input bit inject, output logic [10:0] bits);
        while (line !== 1'b0) @(negedge clk);
        repeat (bc / 2) @(negedge clk);
        bits[0] = line;
        for (int k = 1; k < 11; k++) begin
            if (k == 10 && inject) begin
                repeat (bc / 2) @(negedge clk);
                far_low = 1'b1;
                repeat (bc / 2) @(negedge clk);
            end else begin
                repeat (bc) @(negedge clk);
            end
            bits[k] = line;
        end
        repeat (bc / 2) @(negedge clk);
        far_low = 1'b0;
    endtask

    // Drive a frame as the far end at divisor 0; report the error drive seen.
    task automatic send(input logic [7:0] d, input bit badp,
                        output logic mid_drv, output logic after_drv);
        logic [10:0] b;
        b = frame_of(d, badp);
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            far_low = ~b[k];
            repeat (16) @(negedge clk);
        end
        far_low = 1'b0;
        repeat (8) @(negedge clk);
        mid_drv = line_drive_low;
        repeat (12) @(negedge clk);
        after_drv = line_drive_low;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 line released", line_drive_low, 0);
        chk("R11 txbuf_empty", txbuf_empty, 1);
        chk("R11 tx_done", tx_done, 1);
        chk("R11 rx_full", rx_full, 0);
        chk("R11 irqs", {tx_irq, rx_irq}, 0);
        chk("R11 perr_seen", perr_seen, 0);
    endtask

    task automatic t_tx_basic(input logic [7:0] d);
        logic [10:0] bits;
        tx_en = 1'b1;
        fork
            begin
                host_write(d);
                @(negedge clk);
                chk("R3 buffer empty after hand-off", txbuf_empty, 1);
                chk("R4 tx_done low in frame", tx_done, 0);
            end
            grab(16, 1'b0, bits);
        join
        chk("R1 frame bits", bits, frame_of(d, 1'b0));
        chk("R4 tx_done after frame", tx_done, 1);
        chk("R5 tx_irq set", tx_irq, 1);
        chk("R6 clean frame no remote error", perr_seen, 0);
        repeat (20) @(negedge clk);
        chk("R5 tx_irq held", tx_irq, 1);
        pulse(irq_ack_tx);
        chk("R5 tx_irq acked", tx_irq, 0);
    endtask

    task automatic t_tx_remote_err();
        logic [10:0] bits;
        fork
            host_write(8'h3C);
            grab(16, 1'b1, bits);
        join
        chk("R6 remote error flagged", perr_seen, 1);
        repeat (30) @(negedge clk);
        chk("R6 flag sticky", perr_seen, 1);
        pulse(perr_clr);
        chk("R6 flag cleared", perr_seen, 0);
        pulse(irq_ack_tx);
    endtask

    task automatic t_tx_disabled();
        int lows = 0;
        tx_en = 1'b0;
        host_write(8'h55);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!line) lows++;
        end
        chk("R3 disabled write no frame", lows, 0);
        chk("R3 disabled write buffer", txbuf_empty, 1);
        chk("R4 disabled write tx_done", tx_done, 1);
        tx_en = 1'b1;
    endtask

    task automatic t_back2back();
        logic [10:0] b1, b2;
        fork
            begin
                host_write(8'h81);
                host_write(8'h7E);
                @(negedge clk);
                chk("R10 second byte held", txbuf_empty, 0);
            end
            begin
                grab(16, 1'b0, b1);
                grab(16, 1'b0, b2);
            end
        join
        chk("R10 first frame", b1, frame_of(8'h81, 1'b0));
        chk("R10 second frame", b2, frame_of(8'h7E, 1'b0));
        chk("R10 both done", tx_done, 1);
        pulse(irq_ack_tx);
    endtask

    task automatic t_slow_div();
        logic [10:0] bits;
        int width = 0;
        divisor = 8'd2;
        fork
            host_write(8'h01);
            begin
                while (line !== 1'b0) @(negedge clk);
                while (line !== 1'b1) @(negedge clk);
                while (line !== 1'b0) begin @(negedge clk); width++; end
            end
        join
        chk("R2 bit time divisor 2", width, 48);
        repeat (600) @(negedge clk);
        fork
            host_write(8'hC6);
            grab(48, 1'b0, bits);
        join
        chk("R2 frame at divisor 2", bits, frame_of(8'hC6, 1'b0));
        divisor = '0;
        pulse(irq_ack_tx);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_rx_good();
        logic md, ad;
        tx_en = 1'b0; rx_en = 1'b1;
        send(8'hB4, 1'b0, md, ad);
        chk("R9 no error drive on good parity", md, 0);
        chk("R8 rx_full set", rx_full, 1);
        chk("R8 rd_data", rd_data, 8'hB4);
        chk("R8 rx_irq set", rx_irq, 1);
        chk("R9 rx_perr clear", rx_perr, 0);
        pulse(rd_stb);
        chk("R8 rx_full cleared by read", rx_full, 0);
        chk("R8 rx_irq still set", rx_irq, 1);
        pulse(irq_ack_rx);
        chk("R8 rx_irq acked", rx_irq, 0);
    endtask

    task automatic t_rx_bad();
        logic md, ad;
        send(8'h5A, 1'b1, md, ad);
        chk("R9 error pulse mid stop", md, 1);
        chk("R9 error pulse released", ad, 0);
        chk("R9 rx_perr set", rx_perr, 1);
        chk("R8 rd_data on bad frame", rd_data, 8'h5A);
        pulse(rd_stb);
        pulse(irq_ack_rx);
    endtask

    task automatic t_rx_glitch();
        @(negedge clk); far_low = 1'b1;
        repeat (3) @(negedge clk); far_low = 1'b0;
        repeat (200) @(negedge clk);
        chk("R7 glitch rejected rx_full", rx_full, 0);
        chk("R7 glitch rejected rx_irq", rx_irq, 0);
        chk("R7 glitch no drive", line_drive_low, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_basic(8'hA5);
        t_tx_basic(8'h07);
        t_tx_remote_err();
        t_tx_disabled();
        t_back2back();
        t_slow_div();
        t_rx_good();
        t_rx_bad();
        t_rx_glitch();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule